// File: doc/BRIEF.md
# Flash Command Sequencer with Status

This block decodes byte-wide bus write cycles aimed at a NOR-style flash device. It recognises single-cycle mode commands and two-cycle command sequences: word program, buffered program, factory-program mode and block erase. Each sequence is checked against the cycle that opened it. A good sequence emits a one-cycle start pulse together with the latched address, data, word count and operation type. A bad confirm raises two sticky error bits in the status byte and switches the addressed partition to status reads.

A programmable down-counter stands in for the device's internal write engine. The status byte shows a ready bit that is low while the counter runs. A running word, buffered or erase operation can be suspended and resumed. While it is suspended the counter is frozen and a suspend flag shows which kind of operation was held. Each partition, chosen by the top address bits, has a read-mode bit that selects array data or status data for reads.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte is 0x80, every partition is in array-read mode (part_status_mode all 0), busy is 0 and op_start is 0.
- R2: Command 0x40 or 0x10 followed by any write starts a word program. op_start is high for the one cycle after that second write, with op_kind=1, op_addr and op_data taken from the second write and op_count=1. The partition of that write switches to status mode and stays there after completion.
- R3: Status bit 7 goes low on the edge that starts an operation and returns high exactly BUSY_CYCLES clock edges later, unless the operation is suspended. busy is high for the same span.
- R4: Command 0x20 followed by 0xD0 starts an erase with op_kind=4, using the address and data of the 0xD0 write.
- R5: After 0x20, any second byte other than 0xD0 sets status bits 5 and 4, switches the addressed partition to status mode, starts nothing and returns to idle.
- R6: Command 0xE8, then a count byte c (0..31), then c+1 data writes, then 0xD0 starts a buffered program. op_kind=2, op_count=c+1, op_addr is the address of the count write and op_data is the last data word.
- R7: In the buffered sequence, a count byte of 32 or more, or a final byte other than 0xD0, sets status bits 5 and 4 and starts nothing.
- R8: Command 0x80 followed by 0xD0 starts factory mode (op_kind=3). A byte other than 0xD0 is a sequence error. While factory mode runs, every write is ignored, including suspend and status-read commands.
- R9: While a word, buffered or erase operation runs, only 0x70 (status mode for the addressed partition) and 0xB0 (suspend) take effect. Every other byte leaves modes, status and the op outputs unchanged.
- R10: 0xB0 during a running operation sets status bit 7 and freezes the busy counter. It also sets bit 6 for an erase, or bit 2 for a word or buffered program.
- R11: 0xD0 while suspended clears bits 2 and 6 and drops bit 7. The counter then resumes from where it stopped. While suspended, 0x70 and 0xFF still change the read mode and all other bytes are ignored.
- R12: In idle, 0xFF puts the addressed partition in array mode and 0x70 puts it in status mode. The partition is the top log2(NPART) address bits.
- R13: Status bits 5 and 4 are sticky. Only 0x50 written in idle clears them, and starting other operations does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; top bits select the partition |
| wr_data | input | 8 | Command or data byte |
| status | output | 8 | Status byte: 7 ready, 6 erase held, 5/4 sequence error, 2 program held |
| part_status_mode | output | NPART | Per partition: 1 = status reads, 0 = array reads |
| busy | output | 1 | Busy counter non-zero, including while suspended |
| op_start | output | 1 | One-cycle start pulse to the busy-timer model |
| op_kind | output | 3 | 1 word, 2 buffered, 3 factory, 4 erase |
| op_addr | output | ADDR_W | Latched operation address |
| op_data | output | 8 | Latched operation data |
| op_count | output | CNT_W | Words in the operation |

## Verification
A sequencer state that has gone wrong shows up at the ports on the edge after the next write. That write either starts something it should not, leaves a start pulse missing, or changes a partition's read mode or the error bits at the wrong time. A timer fault shows as bit 7 rising one or more cycles early or late, or moving while the suspend flags are set. Because of this, the per-clock comparison against a behavioural model localises the failure to the cycle of the offending write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;
  localparam logic [7:0] CMD_WORD     = 8'h40;
  localparam logic [7:0] CMD_WORD_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_BUFFER   = 8'hE8;
  localparam logic [7:0] CMD_FACTORY  = 8'h80;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

  typedef enum logic [3:0] {
    S_IDLE, S_PGM_SETUP, S_ERS_SETUP, S_BUF_COUNT, S_BUF_DATA,
    S_BUF_CONFIRM, S_EFP_SETUP, S_RUN, S_EFP_RUN, S_SUSP
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_WORD = 3'd1, OP_BUFFER = 3'd2,
    OP_FACTORY = 3'd3, OP_ERASE = 3'd4
  } op_kind_e;

  // count field holds words-minus-one; it fits when below the buffer size
  function automatic logic count_fits(logic [7:0] field, int unsigned max_words);
    return 32'(field) < max_words;
  endfunction

  // number of words a count field announces
  function automatic int unsigned words_of(logic [7:0] field);
    return 32'(field) + 1;
  endfunction

  // assemble the status byte from its flags
  function automatic logic [7:0] pack_status(logic ready, logic ers_held,
                                             logic err_hi, logic err_lo,
                                             logic pgm_held);
    return {ready, ers_held, err_hi, err_lo, 1'b0, pgm_held, 2'b00};
  endfunction

endpackage

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 16,
  localparam int unsigned TMR_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hold,
  output logic done_evt,
  output logic busy
);

  logic [TMR_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count_q <= '0;
    else if (load)                       count_q <= TMR_W'(BUSY_CYCLES);
    else if (count_q != '0 && !hold)     count_q <= count_q - 1'b1;
  end

  assign done_evt = (count_q == TMR_W'(1)) && !hold;
  assign busy     = (count_q != '0);

  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(count_q));

endmodule

// File: rtl/fcs_status.sv
module fcs_status import flash_cmd_pkg::*; #(
  parameter int unsigned NPART  = 4,
  parameter int unsigned PART_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              done_evt,
  input  logic              susp_evt,
  input  logic              susp_erase,
  input  logic              resume_evt,
  input  logic              err_evt,
  input  logic              clr_evt,
  input  logic              mode_status_evt,
  input  logic              mode_array_evt,
  input  logic [PART_W-1:0] evt_part,
  output logic [7:0]        status,
  output logic [NPART-1:0]  part_mode
);

  logic ready_q, ers_held_q, pgm_held_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b1;
      ers_held_q <= 1'b0;
      pgm_held_q <= 1'b0;
    end else if (start_evt || resume_evt) begin
      ready_q    <= 1'b0;
      ers_held_q <= 1'b0;
      pgm_held_q <= 1'b0;
    end else if (susp_evt) begin
      ready_q    <= 1'b1;
      ers_held_q <= susp_erase;
      pgm_held_q <= !susp_erase;
    end else if (done_evt) begin
      ready_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (err_evt)  err_q <= 1'b1;
    else if (clr_evt)  err_q <= 1'b0;
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    logic hit;
    assign hit = (evt_part == PART_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        part_mode[p] <= 1'b0;
      else if (hit && mode_status_evt)   part_mode[p] <= 1'b1;
      else if (hit && mode_array_evt)    part_mode[p] <= 1'b0;
    end
  end

  assign status = pack_status(ready_q, ers_held_q, err_q, err_q, pgm_held_q);

  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clr_evt) |=> (status[4] && status[5]));

  assert_held_is_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] || status[6]) |-> status[7]);

endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer import flash_cmd_pkg::*; #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PART_W  = 2,
  parameter int unsigned BUF_MAX = 32,
  parameter int unsigned CNT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              done_evt,
  output logic              start_evt,
  output logic              err_evt,
  output logic              susp_evt,
  output logic              resume_evt,
  output logic              clr_evt,
  output logic              mode_status_evt,
  output logic              mode_array_evt,
  output logic [PART_W-1:0] evt_part,
  output logic              hold,
  output logic              efp_run,
  output logic              susp_erase,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [CNT_W-1:0]  op_count
);

  seq_state_e state_q, state_d;
  op_kind_e   kind_q, launch_kind;
  logic [ADDR_W-1:0] launch_addr, buf_addr_q;
  logic [7:0]        launch_data, buf_last_q;
  logic [CNT_W-1:0]  launch_count, buf_total_q, remain_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;
  logic [CNT_W-1:0]  op_count_q;
  logic              op_start_q;
  logic              buf_arm, buf_word;

  assign evt_part = wr_addr[ADDR_W-1 -: PART_W];

  always_comb begin
    state_d         = state_q;
    start_evt       = 1'b0;
    err_evt         = 1'b0;
    susp_evt        = 1'b0;
    resume_evt      = 1'b0;
    clr_evt         = 1'b0;
    mode_status_evt = 1'b0;
    mode_array_evt  = 1'b0;
    buf_arm         = 1'b0;
    buf_word        = 1'b0;
    launch_kind     = OP_NONE;
    launch_addr     = wr_addr;
    launch_data     = wr_data;
    launch_count    = CNT_W'(1);
    if (done_evt && (state_q == S_RUN || state_q == S_EFP_RUN)) begin
      state_d = S_IDLE;
    end else if (wr_en) begin
      unique case (state_q)
        S_IDLE: begin
          unique case (wr_data)
            CMD_ARRAY:              mode_array_evt  = 1'b1;
            CMD_STATUS:             mode_status_evt = 1'b1;
            CMD_CLEAR:              clr_evt         = 1'b1;
            CMD_WORD, CMD_WORD_ALT: state_d = S_PGM_SETUP;
            CMD_ERASE:              state_d = S_ERS_SETUP;
            CMD_BUFFER:             state_d = S_BUF_COUNT;
            CMD_FACTORY:            state_d = S_EFP_SETUP;
            default:                state_d = S_IDLE;
          endcase
        end
        S_PGM_SETUP: begin
          start_evt   = 1'b1;
          launch_kind = OP_WORD;
        end
        S_ERS_SETUP: begin
          if (wr_data == CMD_CONFIRM) begin
            start_evt   = 1'b1;
            launch_kind = OP_ERASE;
          end else begin
            err_evt = 1'b1;
          end
        end
        S_BUF_COUNT: begin
          if (count_fits(wr_data, BUF_MAX)) begin
            buf_arm = 1'b1;
            state_d = S_BUF_DATA;
          end else begin
            err_evt = 1'b1;
          end
        end
        S_BUF_DATA: begin
          buf_word = 1'b1;
          if (remain_q == CNT_W'(1)) state_d = S_BUF_CONFIRM;
        end
        S_BUF_CONFIRM: begin
          if (wr_data == CMD_CONFIRM) begin
            start_evt    = 1'b1;
            launch_kind  = OP_BUFFER;
            launch_addr  = buf_addr_q;
            launch_data  = buf_last_q;
            launch_count = buf_total_q;
          end else begin
            err_evt = 1'b1;
          end
        end
        S_EFP_SETUP: begin
          if (wr_data == CMD_CONFIRM) begin
            start_evt   = 1'b1;
            launch_kind = OP_FACTORY;
          end else begin
            err_evt = 1'b1;
          end
        end
        S_RUN: begin
          if (wr_data == CMD_STATUS) begin
            mode_status_evt = 1'b1;
          end else if (wr_data == CMD_SUSPEND) begin
            susp_evt = 1'b1;
            state_d  = S_SUSP;
          end
        end
        S_EFP_RUN: state_d = S_EFP_RUN;
        S_SUSP: begin
          if (wr_data == CMD_CONFIRM) begin
            resume_evt = 1'b1;
            state_d    = S_RUN;
          end else if (wr_data == CMD_STATUS) begin
            mode_status_evt = 1'b1;
          end else if (wr_data == CMD_ARRAY) begin
            mode_array_evt = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
      if (start_evt) begin
        mode_status_evt = 1'b1;
        state_d = (launch_kind == OP_FACTORY) ? S_EFP_RUN : S_RUN;
      end
      if (err_evt) begin
        mode_status_evt = 1'b1;
        state_d = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      buf_addr_q  <= '0;
      buf_last_q  <= '0;
      buf_total_q <= '0;
      remain_q    <= '0;
    end else begin
      state_q <= state_d;
      if (buf_arm) begin
        buf_addr_q  <= wr_addr;
        buf_total_q <= CNT_W'(words_of(wr_data));
        remain_q    <= CNT_W'(words_of(wr_data));
      end else if (buf_word) begin
        buf_last_q <= wr_data;
        remain_q   <= remain_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q     <= OP_NONE;
      op_addr_q  <= '0;
      op_data_q  <= '0;
      op_count_q <= '0;
      op_start_q <= 1'b0;
    end else begin
      op_start_q <= start_evt;
      if (start_evt) begin
        kind_q     <= launch_kind;
        op_addr_q  <= launch_addr;
        op_data_q  <= launch_data;
        op_count_q <= launch_count;
      end
    end
  end

  assign hold       = (state_q == S_SUSP);
  assign efp_run    = (state_q == S_EFP_RUN);
  assign susp_erase = (kind_q == OP_ERASE);
  assign op_start   = op_start_q;
  assign op_kind    = kind_q;
  assign op_addr    = op_addr_q;
  assign op_data    = op_data_q;
  assign op_count   = op_count_q;

  assert_bad_confirm_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state_q == S_ERS_SETUP && wr_data != CMD_CONFIRM) |=> !op_start_q);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import flash_cmd_pkg::*; #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NPART       = 4,
  parameter int unsigned BUF_MAX     = 32,
  parameter int unsigned BUSY_CYCLES = 16,
  localparam int unsigned PART_W     = $clog2(NPART),
  localparam int unsigned CNT_W      = $clog2(BUF_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        status,
  output logic [NPART-1:0]  part_status_mode,
  output logic              busy,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [CNT_W-1:0]  op_count
);

  logic start_evt, err_evt, susp_evt, resume_evt, clr_evt;
  logic mode_status_evt, mode_array_evt, hold, efp_run, susp_erase, done_evt;
  logic [PART_W-1:0] evt_part;

  fcs_sequencer #(.ADDR_W(ADDR_W), .PART_W(PART_W), .BUF_MAX(BUF_MAX), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_evt(done_evt), .start_evt(start_evt), .err_evt(err_evt), .susp_evt(susp_evt),
    .resume_evt(resume_evt), .clr_evt(clr_evt), .mode_status_evt(mode_status_evt),
    .mode_array_evt(mode_array_evt), .evt_part(evt_part), .hold(hold), .efp_run(efp_run),
    .susp_erase(susp_erase), .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_count(op_count)
  );

  fcs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .hold(hold),
    .done_evt(done_evt), .busy(busy)
  );

  fcs_status #(.NPART(NPART), .PART_W(PART_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .done_evt(done_evt),
    .susp_evt(susp_evt), .susp_erase(susp_erase), .resume_evt(resume_evt),
    .err_evt(err_evt), .clr_evt(clr_evt), .mode_status_evt(mode_status_evt),
    .mode_array_evt(mode_array_evt), .evt_part(evt_part), .status(status),
    .part_mode(part_status_mode)
  );

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  assert_ready_low_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (!status[7] && busy));

  assert_busy_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold && !efp_run && wr_en && wr_data != CMD_STATUS && wr_data != CMD_SUSPEND)
      |=> (!op_start && $stable(part_status_mode)));

  assert_factory_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (efp_run && wr_en) |=> (!op_start && !hold && $stable(part_status_mode)));

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/100ps
module tb_flash_cmd_seq;
  localparam int ADDR_W = 16;
  localparam int NPART  = 4;
  localparam int PART_W = 2;
  localparam int BUSY   = 16;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic [NPART-1:0] part_status_mode;
  logic busy, op_start;
  logic [2:0] op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0] op_data;
  logic [CNT_W-1:0] op_count;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .NPART(NPART), .BUF_MAX(32), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status(status), .part_status_mode(part_status_mode), .busy(busy), .op_start(op_start),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .op_count(op_count));

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference
  typedef enum {M_IDLE, M_PGM, M_ERS, M_BCNT, M_BDAT, M_BCONF, M_EFP, M_RUN, M_ERUN, M_HELD} mphase_t;
  mphase_t ph;
  int m_cnt, m_kind, m_addr, m_data, m_count, need, b_addr, b_last, b_total;
  bit m_run, m_held, m_start, r7, r6, r2, rerr;
  logic [NPART-1:0] m_mode;

  function automatic int part_of(int a);
    return a >> (ADDR_W - PART_W);
  endfunction

  task automatic launch(int k, int a, int d, int n);
    m_start = 1; m_kind = k; m_addr = a; m_data = d; m_count = n;
    r7 = 0; m_run = 1; m_cnt = BUSY; m_mode[part_of(wr_addr)] = 1;
    ph = (k == 3) ? M_ERUN : M_RUN;
  endtask

  task automatic seq_err();
    rerr = 1; m_mode[part_of(wr_addr)] = 1; ph = M_IDLE;
  endtask

  always @(posedge clk) begin
    bit fin;
    int p, d;
    m_start = 0;
    if (!rst_n) begin
      ph = M_IDLE; m_cnt = 0; m_run = 0; m_held = 0; r7 = 1; r6 = 0; r2 = 0; rerr = 0;
      m_mode = '0; m_kind = 0; m_addr = 0; m_data = 0; m_count = 0;
    end else begin
      fin = 0;
      if (m_run && !m_held) begin
        m_cnt--;
        if (m_cnt == 0) begin m_run = 0; r7 = 1; ph = M_IDLE; fin = 1; end
      end
      if (wr_en && !fin) begin
        p = part_of(wr_addr); d = wr_data;
        case (ph)
          M_IDLE: case (d)
            'hFF: m_mode[p] = 0;
            'h70: m_mode[p] = 1;
            'h50: rerr = 0;
            'h40, 'h10: ph = M_PGM;
            'h20: ph = M_ERS;
            'hE8: ph = M_BCNT;
            'h80: ph = M_EFP;
            default: ;
          endcase
          M_PGM: launch(1, wr_addr, d, 1);
          M_ERS: if (d == 'hD0) launch(4, wr_addr, d, 1); else seq_err();
          M_BCNT: if (d > 31) seq_err();
                  else begin need = d + 1; b_total = need; b_addr = wr_addr; ph = M_BDAT; end
          M_BDAT: begin b_last = d; need--; if (need == 0) ph = M_BCONF; end
          M_BCONF: if (d == 'hD0) launch(2, b_addr, b_last, b_total); else seq_err();
          M_EFP: if (d == 'hD0) launch(3, wr_addr, d, 1); else seq_err();
          M_RUN: if (d == 'h70) m_mode[p] = 1;
                 else if (d == 'hB0) begin
                   m_held = 1; r7 = 1; ph = M_HELD;
                   if (m_kind == 4) r6 = 1; else r2 = 1;
                 end
          M_ERUN: ;
          M_HELD: if (d == 'hD0) begin m_held = 0; r7 = 0; r6 = 0; r2 = 0; ph = M_RUN; end
                  else if (d == 'h70) m_mode[p] = 1;
                  else if (d == 'hFF) m_mode[p] = 0;
        endcase
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    logic [7:0] exp_st;
    if (rst_n && !finished) begin
      exp_st = {r7, r6, rerr, rerr, 1'b0, r2, 2'b00};
      vectors++;
      if (status !== exp_st) begin
        fails++; $display("FAIL %s status act=%h exp=%h t=%0t", cur_req, status, exp_st, $time);
      end
      if (part_status_mode !== m_mode) begin
        fails++; $display("FAIL %s modes act=%b exp=%b t=%0t", cur_req, part_status_mode, m_mode, $time);
      end
      if (busy !== m_run || op_start !== m_start) begin
        fails++; $display("FAIL %s busy/start act=%b%b exp=%b%b t=%0t", cur_req, busy, op_start, m_run, m_start, $time);
      end
      if (m_start && (op_kind !== 3'(m_kind) || op_addr !== 16'(m_addr) ||
                      op_data !== 8'(m_data) || op_count !== 6'(m_count))) begin
        fails++;
        $display("FAIL %s op act=%0d/%h/%h/%0d exp=%0d/%h/%h/%0d", cur_req,
                 op_kind, op_addr, op_data, op_count, m_kind, m_addr, m_data, m_count);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++; $display("FAIL %s check act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 16'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      fails++; $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    idle(3); #2 rst_n = 1; idle(2);
    cur_req = "R1"; chk("R1", status, 'h80); chk("R1", part_status_mode, 0); chk("R1", busy, 0);

    cur_req = "R12";
    wr('h4000, 'h70); wr('hC123, 'h70); wr('h4000, 'hFF);
    chk("R12", part_status_mode, 'b1000);

    cur_req = "R2";
    wr('h1234, 'h40); wr('h1234, 'h5A);
    cur_req = "R3"; idle(BUSY - 1); chk("R3", status[7], 0); idle(1); chk("R3", status[7], 1);
    cur_req = "R2";
    wr('h8001, 'h10); wr('h8001, 'hA5); idle(BUSY + 2);
    chk("R2", part_status_mode[2], 1);

    cur_req = "R9";
    wr('h0010, 'h40); wr('h0010, 'h33);
    wr('h0000, 'hFF); wr('h4000, 'h40); wr('h4000, 'h20); wr('h8000, 'hD0); wr('h4000, 'h70);
    idle(BUSY + 2);

    cur_req = "R10";
    wr('h0000, 'hFF); wr('h0020, 'h40); wr('h0020, 'h77); idle(3);
    wr('h0000, 'hB0); chk("R10", status, 'h84); idle(6); chk("R10", busy, 1);
    cur_req = "R11";
    wr('h0000, 'h40); wr('h0000, 'hFF); wr('h0000, 'hD0); chk("R11", status, 'h00);
    idle(BUSY + 2);
    cur_req = "R4";
    wr('h2000, 'h20); wr('h2000, 'hD0); idle(2);
    cur_req = "R10"; wr('h2000, 'hB0); chk("R10", status, 'hC0);
    cur_req = "R11"; wr('h8000, 'h70); wr('h2000, 'hD0); idle(BUSY + 2);

    cur_req = "R5";
    wr('h0000, 'hFF); wr('h4000, 'hFF);
    wr('h4000, 'h20); wr('h4000, 'h40); chk("R5", status, 'hB0); chk("R5", part_status_mode[1], 1);
    cur_req = "R13";
    wr('h0000, 'h40); wr('h0000, 'h11); idle(BUSY + 2); chk("R13", status[5:4], 3);
    wr('h0000, 'h50); chk("R13", status[5:4], 0);

    cur_req = "R6";
    wr('h6000, 'hE8); wr('h6100, 3);
    for (int i = 0; i < 4; i++) wr('h6100 + i, 'h20 + i);
    wr('h6100, 'hD0); idle(BUSY + 2);
    wr('h1000, 'hE8); wr('h1000, 31);
    for (int i = 0; i < 32; i++) wr('h1000 + i, i * 3);
    wr('h1000, 'hD0); idle(BUSY + 2);
    wr('h1000, 'hE8); wr('h1000, 0); wr('h1000, 'hD0); wr('h1000, 'hD0); idle(BUSY + 2);

    cur_req = "R7";
    wr('h0000, 'hE8); wr('h0000, 32); chk("R7", status[5:4], 3); wr('h0000, 'h50);
    wr('h0000, 'hE8); wr('h0000, 1); wr('h0000, 9); wr('h0000, 8); wr('h0000, 'h40);
    chk("R7", status[5:4], 3); wr('h0000, 'h50);

    cur_req = "R8";
    wr('hC000, 'hFF); wr('hC000, 'h80); wr('hC000, 'hD0);
    wr('hC000, 'hB0); wr('h0000, 'hFF); wr('h4000, 'h70); wr('hC000, 'h40); wr('hC000, 'hFF);
    idle(BUSY + 2);
    wr('h0000, 'h80); wr('h0000, 'h20); chk("R8", status[5:4], 3); wr('h0000, 'h50);
    idle(3);
    summary();
  end
endmodule